// File: doc/BRIEF.md
# Per-Stream Sequence Gap Detector

This block sits beside the write port of a packet input buffer. It watches each header word as it is pushed, and it keeps a separate sequence history for each of a fixed number of streams. Each header carries a stream identifier and a sequence number. When a stream that has already been seen delivers a number other than its previous number plus one, the block raises a registered loss pulse for one clock.

A stream is armed by its first header after reset, and that header never raises an alarm. Every header stores the sequence number that actually arrived, so after a gap the tracker follows the new numbering. A single gap therefore raises one alarm, not an alarm on every later packet.

Only the per-stream armed flags are cleared by reset. The sequence-number array has no reset, so it can map onto RAM. The table index is the low bits of the identifier minus one. Identifier 1 maps to slot 0 and identifier 0 wraps to the last slot. The stream count must be a power of two.

Top module: `seq_gap_detector`

## Requirements
- R1: While reset is high at a clock edge, the loss output is low after that edge, and every stream becomes unarmed.
- R2: A header for an unarmed stream never raises the loss output, whatever its sequence number. That stream is armed afterwards.
- R3: A header on an armed stream whose sequence number equals the stored number plus one leaves the loss output low.
- R4: A header on an armed stream whose sequence number differs from the stored number plus one drives the loss output high in the cycle after the header. The output stays high for exactly one clock per offending header, so back-to-back offending headers keep it high on consecutive cycles.
- R5: Each header stores the sequence number it carried. After a gap, a header that follows the received number by one raises no pulse.
- R6: Sequence numbers are 16 bits wide and wrap modulo 65536, so 0xFFFF followed by 0x0000 counts as consecutive.
- R7: The slot is (identifier bits [4:0] minus one) modulo 32, and the upper identifier bits are ignored. Identifiers 1 and 33 share slot 0, and identifiers 0 and 32 share slot 31.
- R8: Streams in different slots keep independent histories, even when their headers are interleaved.
- R9: A cycle with the header strobe low raises no pulse and changes no stored state, whatever values the identifier and sequence inputs hold.
- R10: A reset in the middle of operation disarms all streams, so the next header on a previously armed stream raises no pulse even if its number does not follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_push | input | 1 | A header word is written to the input buffer in this cycle |
| hdr_stream | input | 16 | Stream identifier of the header |
| hdr_seq | input | 16 | Sequence number of the header |
| loss_pulse | output | 1 | Registered one-clock alarm for a sequence discontinuity |

## Verification
The bench builds the block with its default parameters: 32 streams, 16-bit identifiers and 16-bit sequence numbers. The 16-bit sequence width brings the 0xFFFF-to-0x0000 wrap within reach of a single pair of headers. The 16-bit identifier with a 5-bit index lets the bench show that identifiers 1 and 33 alias, and that identifier 0 lands in the last slot. With 32 slots, the bench can interleave several streams while leaving others unarmed, and it can then show that a mid-run reset disarms them all.

// File: rtl/seqgap_pkg.sv
package seqgap_pkg;

  // Classification of one cycle at the header port.
  typedef enum logic [1:0] {
    V_NONE   = 2'd0,  // no header this cycle
    V_FIRST  = 2'd1,  // header arms a fresh stream
    V_FOLLOW = 2'd2,  // header continues its stream
    V_GAP    = 2'd3   // header breaks its stream's sequence
  } verdict_e;

endpackage

// File: rtl/seqgap_slot.sv
module seqgap_slot #(
  parameter int ID_W  = 16,
  parameter int IDX_W = 5
) (
  input  logic [ID_W-1:0]  stream_id,
  output logic [IDX_W-1:0] slot
);

  // Low index bits minus one; wraps so identifier 0 hits the last slot.
  function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] low_bits);
    return low_bits - IDX_W'(1);
  endfunction

  assign slot = slot_of(stream_id[IDX_W-1:0]);

  generate
    if (ID_W > IDX_W) begin : g_drop_hi
      logic unused_id_hi;
      assign unused_id_hi = ^stream_id[ID_W-1:IDX_W];
    end
  endgenerate

endmodule

// File: rtl/seqgap_table.sv
module seqgap_table #(
  parameter int NUM_STREAMS = 32,
  parameter int SEQ_W       = 16,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_slot,
  input  logic [SEQ_W-1:0]       wr_seq,
  input  logic [IDX_W-1:0]       rd_slot,
  output logic                   rd_armed,
  output logic [SEQ_W-1:0]       rd_seq,
  output logic [NUM_STREAMS-1:0] armed_vec
);

  logic [NUM_STREAMS-1:0] armed_q;
  logic [SEQ_W-1:0]       last_seq [NUM_STREAMS];

  // Only the armed flags are reset.
  always_ff @(posedge clk) begin
    if (rst) armed_q <= '0;
    else if (wr_en) armed_q[wr_slot] <= 1'b1;
  end

  // Reset-free storage so it can be mapped to RAM.
  always_ff @(posedge clk) begin
    if (wr_en) last_seq[wr_slot] <= wr_seq;
  end

  assign rd_armed  = armed_q[rd_slot];
  assign rd_seq    = last_seq[rd_slot];
  assign armed_vec = armed_q;

endmodule

// File: rtl/seqgap_judge.sv
module seqgap_judge
  import seqgap_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             push,
  input  logic             armed,
  input  logic [SEQ_W-1:0] stored_seq,
  input  logic [SEQ_W-1:0] new_seq,
  output logic             follows,
  output verdict_e         verdict
);

  // Successor with modular wrap.
  function automatic logic [SEQ_W-1:0] succ(input logic [SEQ_W-1:0] s);
    return s + SEQ_W'(1);
  endfunction

  assign follows = (new_seq == succ(stored_seq));

  always_comb begin
    verdict = V_NONE;
    if (push) begin
      if (!armed)       verdict = V_FIRST;
      else if (follows) verdict = V_FOLLOW;
      else              verdict = V_GAP;
    end
  end

endmodule

// File: rtl/seq_gap_detector.sv
module seq_gap_detector
  import seqgap_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int ID_W        = 16,
  parameter int SEQ_W       = 16,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_push,
  input  logic [ID_W-1:0]  hdr_stream,
  input  logic [SEQ_W-1:0] hdr_seq,
  output logic             loss_pulse
);

  // Named internal events, visible to the bound checker.
  logic [IDX_W-1:0]       slot;
  logic                   tbl_armed;
  logic [SEQ_W-1:0]       tbl_seq;
  logic [NUM_STREAMS-1:0] armed_vec;
  logic                   seq_follows;
  verdict_e               verdict;
  logic                   loss_q;

  seqgap_slot #(.ID_W(ID_W), .IDX_W(IDX_W)) u_slot (
    .stream_id (hdr_stream),
    .slot      (slot)
  );

  seqgap_table #(.NUM_STREAMS(NUM_STREAMS), .SEQ_W(SEQ_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (hdr_push),
    .wr_slot   (slot),
    .wr_seq    (hdr_seq),
    .rd_slot   (slot),
    .rd_armed  (tbl_armed),
    .rd_seq    (tbl_seq),
    .armed_vec (armed_vec)
  );

  seqgap_judge #(.SEQ_W(SEQ_W)) u_judge (
    .push       (hdr_push),
    .armed      (tbl_armed),
    .stored_seq (tbl_seq),
    .new_seq    (hdr_seq),
    .follows    (seq_follows),
    .verdict    (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) loss_q <= 1'b0;
    else     loss_q <= (verdict == V_GAP);
  end

  assign loss_pulse = loss_q;

endmodule

// File: rtl/seq_gap_detector_chk.sv
module seq_gap_detector_chk #(
  parameter int NUM_STREAMS = 32,
  parameter int SEQ_W       = 16,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   hdr_push,
  input logic [SEQ_W-1:0]       hdr_seq,
  input logic                   loss_pulse,
  input logic [IDX_W-1:0]       slot,
  input logic                   tbl_armed,
  input logic [SEQ_W-1:0]       tbl_seq,
  input logic [NUM_STREAMS-1:0] armed_vec,
  input logic                   seq_follows
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (armed_vec == '0) && !loss_pulse);

  p_first_silent_r2: assert property (@(posedge clk) disable iff (rst)
    hdr_push && !tbl_armed |=> !loss_pulse);

  p_follow_silent_r3: assert property (@(posedge clk) disable iff (rst)
    hdr_push && tbl_armed && (hdr_seq == SEQ_W'(tbl_seq + 1'b1)) |=> !loss_pulse);

  p_gap_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    hdr_push && tbl_armed && (hdr_seq != SEQ_W'(tbl_seq + 1'b1)) |=> loss_pulse);

  // R6: the judge's match flag agrees with modular successor arithmetic.
  p_wrap_match_r6: assert property (@(posedge clk) disable iff (rst)
    (tbl_seq == '1 && hdr_seq == '0) |-> seq_follows);

  p_arms_slot_r7: assert property (@(posedge clk) disable iff (rst)
    hdr_push |=> armed_vec[$past(slot)]);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !hdr_push |=> !loss_pulse && $stable(armed_vec));

endmodule

bind seq_gap_detector seq_gap_detector_chk #(
  .NUM_STREAMS (NUM_STREAMS),
  .SEQ_W       (SEQ_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hdr_push    (hdr_push),
  .hdr_seq     (hdr_seq),
  .loss_pulse  (loss_pulse),
  .slot        (slot),
  .tbl_armed   (tbl_armed),
  .tbl_seq     (tbl_seq),
  .armed_vec   (armed_vec),
  .seq_follows (seq_follows)
);

// File: tb/test_seq_gap_detector.sv
module test_seq_gap_detector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_push = 1'b0;
  logic [15:0] hdr_stream = '0;
  logic [15:0] hdr_seq = '0;
  logic        loss_pulse;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  seq_gap_detector i_seq_gap_detector (
    .clk        (clk),
    .rst        (rst),
    .hdr_push   (hdr_push),
    .hdr_stream (hdr_stream),
    .hdr_seq    (hdr_seq),
    .loss_pulse (loss_pulse)
  );

  // {push, stream id, seq, expected loss one cycle later, requirement number}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 16'd1,  16'd10,     1'b0, 4'd2},  // R2 first header arms id 1
    {1'b1, 16'd1,  16'd11,     1'b0, 4'd3},  // R3 consecutive
    {1'b1, 16'd1,  16'd13,     1'b1, 4'd4},  // R4 gap
    {1'b1, 16'd1,  16'd14,     1'b0, 4'd5},  // R5 resync to 13
    {1'b0, 16'd1,  16'd0,      1'b0, 4'd9},  // R9 idle
    {1'b1, 16'd2,  16'd500,    1'b0, 4'd2},  // R2 arms id 2
    {1'b1, 16'd1,  16'd15,     1'b0, 4'd8},  // R8 interleave
    {1'b1, 16'd2,  16'd502,    1'b1, 4'd8},  // R8 gap on id 2 only
    {1'b1, 16'd33, 16'd16,     1'b0, 4'd7},  // R7 id 33 aliases id 1
    {1'b1, 16'd0,  16'hFFFF,   1'b0, 4'd7},  // R7 id 0 -> slot 31, first
    {1'b1, 16'd32, 16'h0000,   1'b0, 4'd6},  // R6 wrap, id 32 aliases id 0
    {1'b1, 16'd0,  16'h0000,   1'b1, 4'd4},  // R4 repeated number is a gap
    {1'b1, 16'd2,  16'd503,    1'b0, 4'd5},  // R5 resync on id 2
    {1'b1, 16'd3,  16'd7,      1'b0, 4'd2},  // R2 arms id 3
    {1'b1, 16'd3,  16'd7,      1'b1, 4'd4},  // R4 duplicate
    {1'b0, 16'd3,  16'd8,      1'b0, 4'd9}   // R9 pulse ends, no update
  };

  task automatic check(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: loss_pulse=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // Called just after a falling edge; the result is sampled at the next one.
  task automatic apply(input logic p, input logic [15:0] id, input logic [15:0] sq,
                       input logic e, input string req);
    hdr_push = p; hdr_stream = id; hdr_seq = sq;
    @(negedge clk);
    check(loss_pulse, e, req);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(loss_pulse, 1'b0, "R1 reset state");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][37], VEC[k][36:21], VEC[k][20:5], VEC[k][4],
            $sformatf("R%0d vector %0d", VEC[k][3:0], k));
    end
    // stored 8 must not exist on id 3: 7 stays, so 8 follows
    apply(1'b1, 16'd3, 16'd8, 1'b0, "R9 idle cycle left id 3 untouched");

    // back-to-back gaps: one pulse per header, then drop
    apply(1'b1, 16'd4, 16'd1, 1'b0, "R2 arm id 4");
    apply(1'b1, 16'd4, 16'd5, 1'b1, "R4 first gap");
    apply(1'b1, 16'd4, 16'd9, 1'b1, "R4 second gap");
    apply(1'b0, 16'd4, 16'd0, 1'b0, "R4 pulse width");
    apply(1'b0, 16'd4, 16'd3, 1'b0, "R9 idle with junk");
    apply(1'b1, 16'd4, 16'd10, 1'b0, "R9 stored 9 kept");

    // mid-run reset disarms everything
    hdr_push = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(loss_pulse, 1'b0, "R1 reset mid-run");
    rst = 1'b0;
    apply(1'b1, 16'd1, 16'd999, 1'b0, "R10 rearm after reset");
    apply(1'b1, 16'd1, 16'd1000, 1'b0, "R10 consecutive after rearm");
    apply(1'b1, 16'd1, 16'd1002, 1'b1, "R10 gap after rearm");
    apply(1'b1, 16'd4, 16'd0, 1'b0, "R10 id 4 disarmed too");
    apply(1'b0, 16'd0, 16'd0, 1'b0, "R9 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule